// File: doc/BRIEF.md
# PCI Bus Fault Monitor

This block sits beside the host-side arbiter of a PCI-style bus and watches two protocol faults on the shared control lines. One fault is a stalled master: the bus is idle and a master holds the grant, but it never drives FRAME# low. The other is a slow target: the initiator has asserted IRDY# for a data phase, but neither TRDY# nor STOP# comes back in time. The limit for the first data phase of a transaction is longer than the limit for the phases that follow.

Detected faults go into a 32-bit status word. The host reads it and clears it by writing ones. A second, read-only copy of the word is presented to the PCI side. Only the first fault is kept. Later faults are ignored until software empties the register. A fault is recorded even when its interrupt is masked. The interrupt line is the OR of the recorded faults that are also enabled.

All bus inputs are active low and are sampled on the rising edge of `clk`. Reset is synchronous and active high.

Top module: `pci_fault_monitor`

## Requirements
- R1: After reset, both read ports return 0 and `irq` is low.
- R2: Bit 13 (stalled master) is set when `gnt_n` is low with FRAME# and IRDY# both high for 16 consecutive clock cycles. If FRAME# goes low or the grant is removed before the 16th cycle, no fault is recorded and the count starts again.
- R3: Bit 12 (slow target) is set when, in the first data phase after an idle bus, IRDY# is low while TRDY# and STOP# are both high for 16 consecutive cycles.
- R4: Once a data phase has completed with TRDY# low, the slow-target limit for the following data phases of the same transaction is 8 consecutive cycles.
- R5: A data phase that ends with TRDY# or STOP# low before its limit is reached records no fault.
- R6: While any status bit is set, further detections set no further bits. If both faults are detected in the same cycle on an empty register, both bits are set.
- R7: A fault whose enable is low still sets its status bit but leaves `irq` low. Enable bit 1 belongs to the stalled-master fault and enable bit 0 to the slow-target fault.
- R8: `irq` is high exactly when a status bit and its enable are both set. It updates on the clock edge after a change in status or enable, and it stays high until software clears the bit.
- R9: A host write clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. `pci_rdata` always equals `host_rdata`.
- R10: Bits 31 to 14 and bits 11 to 0 always read 0, whatever is written to them.
- R11: If a clearing write and a new detection happen in the same cycle, and the write leaves the register empty, the new fault is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| gnt_n | input | 1 | Grant given to the current master, active low |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| stop_n | input | 1 | STOP#, active low |
| irq_en | input | 2 | Interrupt enables: bit 1 stalled master, bit 0 slow target |
| host_wr | input | 1 | Host write strobe for the status word |
| host_wdata | input | 32 | Host write data; a 1 clears the matching status bit |
| host_rdata | output | 32 | Host view of the status word |
| pci_rdata | output | 32 | Read-only PCI-side view of the status word |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-cycle grant window, a 16-cycle first-phase window, an 8-cycle later-phase window, and the stalled-master and slow-target flags at bits 13 and 12. With these values each window can be driven to one cycle short of its limit and then to exactly its limit within a few dozen cycles, so both sides of every boundary are checked. The same values let the bench make a clearing write land on the exact cycle of a new detection.

// File: rtl/pci_fault_pkg.sv
package pci_fault_pkg;
  localparam int REG_W = 32;

  typedef struct packed {
    logic stall_master;
    logic slow_target;
  } fault_t;
endpackage

// File: rtl/grant_watch.sv
module grant_watch #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic gnt_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          waiting;

  // granted master with an idle bus that has not started yet
  assign waiting = !gnt_n && frame_n && irdy_n;
  assign hit     = waiting && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!waiting) begin
      cnt_q <= '0;
    end else if (cnt_q < TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_STALL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    hit |-> (frame_n && !gnt_n)); // R2
  AST_STALL_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP); // R2
endmodule

// File: rtl/target_watch.sv
module target_watch #(
  parameter int FIRST_LIMIT = 16,
  parameter int NEXT_LIMIT  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic trdy_n,
  input  logic stop_n,
  output logic hit
);
  localparam int MAXL = (FIRST_LIMIT > NEXT_LIMIT) ? FIRST_LIMIT : NEXT_LIMIT;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] LAST_FIRST = CW'(FIRST_LIMIT - 1);
  localparam logic [CW-1:0] LAST_NEXT  = CW'(NEXT_LIMIT - 1);
  localparam logic [CW-1:0] TOP        = CW'(MAXL);

  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          waiting;
  logic          ended;
  logic [CW-1:0] last;

  assign waiting = !irdy_n && trdy_n && stop_n;
  assign ended   = !irdy_n && (!trdy_n || !stop_n);
  assign last    = first_q ? LAST_FIRST : LAST_NEXT;
  assign hit     = waiting && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      if (frame_n && irdy_n) begin
        first_q <= 1'b1;
      end else if (ended) begin
        first_q <= 1'b0;
      end
      if (!waiting) begin
        cnt_q <= '0;
      end else if (cnt_q < TOP) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_SLOW_NEEDS_WAIT: assert property (@(posedge clk) disable iff (rst)
    hit |-> (trdy_n && stop_n && !irdy_n)); // R5
  AST_SLOW_FIRST_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    (frame_n && irdy_n) |=> first_q); // R3
endmodule

// File: rtl/fault_status.sv
module fault_status
  import pci_fault_pkg::*;
#(
  parameter int STALL_BIT = 13,
  parameter int SLOW_BIT  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  fault_t           det,
  input  logic [1:0]       irq_en,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] status,
  output logic             irq
);
  fault_t stat_q;
  fault_t clr;
  fault_t kept;
  fault_t nxt;

  always_comb begin
    clr.stall_master = host_wr && host_wdata[STALL_BIT];
    clr.slow_target  = host_wr && host_wdata[SLOW_BIT];
    kept = stat_q & ~clr;
    // only the first fault is kept; a detection wins over a clear that empties the word
    nxt  = (kept == '0) ? det : kept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= nxt;
      irq    <= |(nxt & irq_en);
    end
  end

  always_comb begin
    status            = '0;
    status[STALL_BIT] = stat_q.stall_master;
    status[SLOW_BIT]  = stat_q.slow_target;
  end

  AST_FIRST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst)
    ((stat_q != '0) && !host_wr) |=> (stat_q == $past(stat_q))); // R6
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat_q != '0)); // R8
  AST_CLEAR_LOSES_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    ((stat_q == '0) && (det != '0)) |=> (stat_q == $past(det))); // R11
endmodule

// File: rtl/pci_fault_monitor.sv
module pci_fault_monitor
  import pci_fault_pkg::*;
#(
  parameter int GRANT_LIMIT = 16,
  parameter int FIRST_LIMIT = 16,
  parameter int NEXT_LIMIT  = 8,
  parameter int STALL_BIT   = 13,
  parameter int SLOW_BIT    = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        gnt_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        trdy_n,
  input  logic        stop_n,
  input  logic [1:0]  irq_en,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic [31:0] pci_rdata,
  output logic        irq
);
  fault_t           det;
  logic [REG_W-1:0] status;

  grant_watch #(.LIMIT(GRANT_LIMIT)) u_grant (
    .clk(clk), .rst(rst), .gnt_n(gnt_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .hit(det.stall_master)
  );

  target_watch #(.FIRST_LIMIT(FIRST_LIMIT), .NEXT_LIMIT(NEXT_LIMIT)) u_target (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .hit(det.slow_target)
  );

  fault_status #(.STALL_BIT(STALL_BIT), .SLOW_BIT(SLOW_BIT)) u_status (
    .clk(clk), .rst(rst), .det(det), .irq_en(irq_en), .host_wr(host_wr),
    .host_wdata(host_wdata), .status(status), .irq(irq)
  );

  assign host_rdata = status;
  assign pci_rdata  = status;

  AST_VIEWS_MATCH: assert property (@(posedge clk) disable iff (rst)
    pci_rdata == host_rdata); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rdata[31:14] == '0) && (host_rdata[11:0] == '0)); // R10
endmodule

// File: tb/pci_fault_monitor_bench.sv
module pci_fault_monitor_bench;
  localparam logic [31:0] STALL = 32'h0000_2000;
  localparam logic [31:0] SLOW  = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gnt_n = 1'b1, frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
  logic [1:0]  irq_en = 2'b11;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata, pci_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pci_fault_monitor u_pci_fault_monitor (
    .clk(clk), .rst(rst), .gnt_n(gnt_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .irq_en(irq_en), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pci_rdata(pci_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_bus();
    gnt_n = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
    cycles(2);
  endtask

  task automatic host_write(input logic [31:0] d);
    host_wr = 1'b1; host_wdata = d;
    cycles(1);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic clear_all();
    idle_bus();
    host_write(32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    cycles(3);
    rst = 1'b0;
    cycles(1);
    chk("R1 host_rdata", host_rdata, 32'h0);
    chk("R1 pci_rdata", pci_rdata, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_stall();
    gnt_n = 1'b0; cycles(15);
    chk("R2 15 granted cycles", host_rdata, 32'h0);
    gnt_n = 1'b1; cycles(1);
    gnt_n = 1'b0; cycles(15);
    frame_n = 1'b0; cycles(3);
    chk("R2 frame starts in time", host_rdata, 32'h0);
    frame_n = 1'b1; gnt_n = 1'b1; cycles(1);
    gnt_n = 1'b0; cycles(16);
    chk("R2 16 granted cycles", host_rdata, STALL);
    chk("R8 irq on enabled stall", {31'h0, irq}, 32'h1);
    chk("R9 pci view", pci_rdata, STALL);
    clear_all();
  endtask

  task automatic t_target();
    frame_n = 1'b0; irdy_n = 1'b0;
    cycles(15);
    chk("R3 first phase 15 cycles", host_rdata, 32'h0);
    trdy_n = 1'b0; cycles(1);
    trdy_n = 1'b1; cycles(7);
    chk("R4 later phase 7 cycles", host_rdata, 32'h0);
    stop_n = 1'b0; cycles(1);
    chk("R5 stop ends phase", host_rdata, 32'h0);
    stop_n = 1'b1; cycles(8);
    chk("R4 later phase 8 cycles", host_rdata, SLOW);
    clear_all();
    frame_n = 1'b0; irdy_n = 1'b0;
    cycles(16);
    chk("R3 first phase 16 cycles", host_rdata, SLOW);
    clear_all();
  endtask

  task automatic t_lock();
    gnt_n = 1'b0; cycles(16);
    gnt_n = 1'b1; frame_n = 1'b0; irdy_n = 1'b0;
    cycles(20);
    chk("R6 later fault ignored", host_rdata, STALL);
    host_write(SLOW);
    chk("R9 zero bit write keeps", host_rdata, STALL);
    clear_all();
    chk("R9 write one clears", host_rdata, 32'h0);
  endtask

  task automatic t_mask();
    irq_en = 2'b01;
    gnt_n = 1'b0; cycles(16);
    gnt_n = 1'b1;
    chk("R7 masked fault recorded", host_rdata, STALL);
    chk("R7 masked irq low", {31'h0, irq}, 32'h0);
    irq_en = 2'b10; cycles(1);
    chk("R8 irq follows enable", {31'h0, irq}, 32'h1);
    cycles(5);
    chk("R8 irq held", {31'h0, irq}, 32'h1);
    clear_all();
    chk("R8 irq drops on clear", {31'h0, irq}, 32'h0);
    irq_en = 2'b11;
  endtask

  task automatic t_race();
    gnt_n = 1'b0; cycles(16);
    gnt_n = 1'b1; frame_n = 1'b0; irdy_n = 1'b0;
    cycles(15);
    host_write(STALL);
    chk("R11 detection beats clear", host_rdata, SLOW);
    clear_all();
  endtask

  task automatic t_reserved();
    host_write(32'hFFFF_FFFF);
    chk("R10 reserved read zero", host_rdata, 32'h0);
    chk("R10 pci reserved zero", pci_rdata, 32'h0);
    gnt_n = 1'b0; cycles(16);
    gnt_n = 1'b1;
    host_write(32'hFFFF_CFFF);
    chk("R10 reserved write ignored", host_rdata, STALL);
    clear_all();
  endtask

  initial begin
    t_reset();
    t_stall();
    t_target();
    t_lock();
    t_mask();
    t_race();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule